// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a matrix of mechanical switches with up to six rows and five columns. It pulls one column low at a time, reads the row lines through a synchronizer, and treats a low row as a closed switch at the crossing of that row and the driven column. Scanning, debouncing and release detection all advance on a slow tick input, typically about 1 kHz, so every time setting is counted in ticks.

Software configures the active matrix size, how long each column stays driven and how long a reading must hold before it counts. It then starts hardware scanning. When a press qualifies, the driven column pattern and the row pattern are latched, and a sticky key flag is raised. The flag can also drive an interrupt line. Scanning then pauses on that column until every active row has read high for the whole debounce time, and it restarts from the first column. In bypass mode the scanner is parked, software drives the column lines itself, and it reads the live rows.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, all column outputs are high, the interrupt is low, the control register reads 0x00, the column register reads 0x1F and the row register reads 0x3F.
- R2: Register map (3-bit address, 8-bit data). Address 0 is control: bit0 scan enable, bit1 interrupt enable, bit2 bypass, bit3 key flag (writing 1 clears it). Address 1 is size: bits [2:0] row count, bits [6:4] column count; a count of 0 or above the maximum acts as the maximum. Address 2 is debounce ticks and address 3 is ticks per column; 0 acts as 1 in both. Address 4 is the column register and address 5 is the row register. The size register reads back as written.
- R3: While scanning, at most one column output is low. Column 0 is driven first, each column is held for the programmed number of ticks, and the scan wraps after the last active column.
- R4: A low reading on an active row starts qualification. The press is accepted only when the same row pattern is seen on each of the following debounce-count ticks. The column register then holds the driven pattern (0 at the column bit) and the row register holds the row pattern (0 at the row bit), and the key flag is set.
- R5: If the row pattern changes during qualification, the press is discarded and the flag stays clear.
- R6: Rows at or above the active row count are ignored. Columns at or above the active column count are never driven low.
- R7: After acceptance the column stays driven and no new press is reported. Release needs every active row high on debounce-count consecutive ticks after the tick that first sees them high. Any low row during this wait restarts it. Scanning then resumes at column 0.
- R8: The key flag is set whether or not the interrupt is enabled. The interrupt output is the flag ANDed with the interrupt enable.
- R9: In bypass, scanning stops, the column outputs follow the column register, software writes to that register take effect, and the row register reads the live synchronized rows. Outside bypass, software writes to the column register are ignored.
- R10: With scanning disabled and bypass off, all column outputs stay high and no press is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle scan tick pulse (about 1 kHz) |
| row_i | input | 6 | Row sense lines, low means a closed switch |
| col_o | output | 5 | Column drive lines, low means driven |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Key-detect interrupt |

## Verification
The bench models the switch matrix behaviourally, so a row goes low only while its pressed key's column is actually driven. The tests use a steady press, which separates correct timing from detection one tick early or late. A press that bounces open during qualification checks that an unstable reading is rejected. A release that bounces closed checks that the release wait restarts. A key on a row outside the active size checks masking, and the same key after a size of zero checks the clamp to the maximum. Bypass and disabled runs with a held key show that the scanner neither drives columns nor reports a press when it is parked.

// File: rtl/kps_pkg.sv
package kps_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int SZ_W   = 3;
    localparam int CNT_W  = 8;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_SIZE = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_DEB  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_RATE = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_COL  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_ROW  = 3'd5;

    typedef enum logic [1:0] {
        ST_SCAN    = 2'd0,
        ST_PRESS   = 2'd1,
        ST_HOLD    = 2'd2,
        ST_RELEASE = 2'd3
    } kps_state_e;

    typedef struct packed {
        logic bypass;
        logic irq_en;
        logic scan_en;
    } kps_ctrl_t;

    // a programmed count of zero behaves as one
    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    // true when one more tick completes a window of lim ticks
    function automatic logic window_done(input logic [CNT_W-1:0] cnt,
                                         input logic [CNT_W-1:0] lim);
        return ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, lim};
    endfunction
endpackage

// File: rtl/kps_sync.sv
module kps_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/kps_fsm.sv
module kps_fsm
    import kps_pkg::*;
#(
    parameter int NROW = 6,
    parameter int NCOL = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic [SZ_W-1:0]  n_rows_i,
    input  logic [SZ_W-1:0]  n_cols_i,
    input  logic [CNT_W-1:0] deb_i,
    input  logic [CNT_W-1:0] rate_i,
    input  logic [NROW-1:0]  rows_i,
    output logic [NCOL-1:0]  col_drive_o,
    output logic             det_o,
    output logic [NCOL-1:0]  det_col_o,
    output logic [NROW-1:0]  det_row_o
);
    localparam int CIDX_W = (NCOL > 1) ? $clog2(NCOL) : 1;

    kps_state_e        state;
    logic [CIDX_W-1:0] cidx;
    logic [CNT_W-1:0]  cnt;
    logic [NROW-1:0]   cand;
    logic [NROW-1:0]   row_en;
    logic [NROW-1:0]   masked;
    logic [CNT_W-1:0]  deb_e;
    logic [CNT_W-1:0]  rate_e;
    logic              any_low;

    genvar gr, gc;
    generate
        for (gr = 0; gr < NROW; gr++) begin : g_row_en
            assign row_en[gr] = (gr < int'(n_rows_i));
        end
        for (gc = 0; gc < NCOL; gc++) begin : g_col_drv
            assign col_drive_o[gc] = !(active_i && (int'(cidx) == gc) && (gc < int'(n_cols_i)));
        end
    endgenerate

    assign masked  = rows_i | ~row_en;
    assign any_low = ~&masked;
    assign deb_e   = at_least_one(deb_i);
    assign rate_e  = at_least_one(rate_i);

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            state <= ST_SCAN;
            cidx  <= '0;
            cnt   <= '0;
            cand  <= '1;
            det_o <= 1'b0;
            if (rst) begin
                det_col_o <= '1;
                det_row_o <= '1;
            end
        end else begin
            det_o <= 1'b0;
            if (tick_i) begin
                unique case (state)
                    ST_SCAN: begin
                        if (any_low) begin
                            state <= ST_PRESS;
                            cand  <= masked;
                            cnt   <= '0;
                        end else if (window_done(cnt, rate_e)) begin
                            cnt  <= '0;
                            cidx <= (int'(cidx) + 1 >= int'(n_cols_i)) ? '0 : cidx + CIDX_W'(1);
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_PRESS: begin
                        if (masked != cand) begin
                            state <= ST_SCAN;
                            cnt   <= '0;
                        end else if (window_done(cnt, deb_e)) begin
                            state     <= ST_HOLD;
                            cnt       <= '0;
                            det_o     <= 1'b1;
                            det_col_o <= col_drive_o;
                            det_row_o <= cand;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_HOLD: begin
                        if (!any_low) begin
                            state <= ST_RELEASE;
                            cnt   <= '0;
                        end
                    end
                    ST_RELEASE: begin
                        if (any_low) begin
                            state <= ST_HOLD;
                            cnt   <= '0;
                        end else if (window_done(cnt, deb_e)) begin
                            state <= ST_SCAN;
                            cidx  <= '0;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: state <= ST_SCAN;
                endcase
            end
        end
    end

    // R3: never more than one column pulled low
    a_r3_one_col: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~col_drive_o));

    // R4: a report comes only out of a qualifying press
    a_r4_det_after_press: assert property (@(posedge clk) disable iff (rst)
        det_o |-> (state == ST_HOLD && $past(state) == ST_PRESS));

    // R7: the held column does not move while waiting for release
    a_r7_hold_steady: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && $past(state) == ST_HOLD && $past(active_i)) |-> $stable(cidx));

    // R10: a parked scanner restarts from the first column
    a_r10_idle_home: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> (cidx == '0 && state == ST_SCAN));
endmodule

// File: rtl/kps_regs.sv
module kps_regs
    import kps_pkg::*;
#(
    parameter int NROW = 6,
    parameter int NCOL = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output kps_ctrl_t         ctrl_o,
    output logic [SZ_W-1:0]   n_rows_o,
    output logic [SZ_W-1:0]   n_cols_o,
    output logic [CNT_W-1:0]  deb_o,
    output logic [CNT_W-1:0]  rate_o,
    input  logic              det_i,
    input  logic [NCOL-1:0]   det_col_i,
    input  logic [NROW-1:0]   det_row_i,
    input  logic [NROW-1:0]   live_row_i,
    output logic [NCOL-1:0]   col_reg_o,
    output logic              flag_o
);
    logic [SZ_W-1:0] rows_f, cols_f;
    logic [NROW-1:0] row_reg;
    logic            wr_ctrl, wr_col;

    assign wr_ctrl = wr_i && (addr_i == ADR_CTRL);
    assign wr_col  = wr_i && (addr_i == ADR_COL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o    <= '0;
            rows_f    <= '0;
            cols_f    <= '0;
            deb_o     <= '0;
            rate_o    <= '0;
            col_reg_o <= '1;
            row_reg   <= '1;
            flag_o    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_o.scan_en <= wdata_i[0];
                ctrl_o.irq_en  <= wdata_i[1];
                ctrl_o.bypass  <= wdata_i[2];
            end
            if (wr_i && addr_i == ADR_SIZE) begin
                rows_f <= wdata_i[SZ_W-1:0];
                cols_f <= wdata_i[SZ_W+3:4];
            end
            if (wr_i && addr_i == ADR_DEB)  deb_o  <= wdata_i[CNT_W-1:0];
            if (wr_i && addr_i == ADR_RATE) rate_o <= wdata_i[CNT_W-1:0];

            if (det_i) begin
                flag_o    <= 1'b1;
                col_reg_o <= det_col_i;
                row_reg   <= det_row_i;
            end else begin
                if (wr_ctrl && wdata_i[3]) flag_o <= 1'b0;
                if (wr_col && ctrl_o.bypass) col_reg_o <= wdata_i[NCOL-1:0];
            end
        end
    end

    assign n_rows_o = (rows_f == '0 || int'(rows_f) > NROW) ? SZ_W'(NROW) : rows_f;
    assign n_cols_o = (cols_f == '0 || int'(cols_f) > NCOL) ? SZ_W'(NCOL) : cols_f;

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADR_CTRL: rdata_o = {4'b0, flag_o, ctrl_o.bypass, ctrl_o.irq_en, ctrl_o.scan_en};
            ADR_SIZE: rdata_o = {1'b0, cols_f, 1'b0, rows_f};
            ADR_DEB:  rdata_o = deb_o;
            ADR_RATE: rdata_o = rate_o;
            ADR_COL:  rdata_o = {{(DATA_W-NCOL){1'b0}}, col_reg_o};
            ADR_ROW:  rdata_o = {{(DATA_W-NROW){1'b0}}, (ctrl_o.bypass ? live_row_i : row_reg)};
            default:  rdata_o = '0;
        endcase
    end

    // R8: an accepted press always raises the flag
    a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
        det_i |=> flag_o);

    // R9: column writes outside bypass leave the register untouched
    a_r9_col_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_col && !ctrl_o.bypass && !det_i) |=> $stable(col_reg_o));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kps_pkg::*;
#(
    parameter int NROW = 6,
    parameter int NCOL = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [NROW-1:0]   row_i,
    output logic [NCOL-1:0]   col_o,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    kps_ctrl_t        ctrl;
    logic [SZ_W-1:0]  n_rows, n_cols;
    logic [CNT_W-1:0] deb, rate;
    logic [NROW-1:0]  row_s;
    logic [NCOL-1:0]  col_drive, det_col, col_reg;
    logic [NROW-1:0]  det_row;
    logic             det, flag, active;

    kps_sync #(.WIDTH(NROW), .STAGES(2)) i_sync (
        .clk(clk), .rst(rst), .d_i(row_i), .q_o(row_s)
    );

    kps_regs #(.NROW(NROW), .NCOL(NCOL)) i_regs (
        .clk(clk), .rst(rst),
        .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
        .ctrl_o(ctrl), .n_rows_o(n_rows), .n_cols_o(n_cols),
        .deb_o(deb), .rate_o(rate),
        .det_i(det), .det_col_i(det_col), .det_row_i(det_row),
        .live_row_i(row_s), .col_reg_o(col_reg), .flag_o(flag)
    );

    assign active = ctrl.scan_en && !ctrl.bypass;

    kps_fsm #(.NROW(NROW), .NCOL(NCOL)) i_fsm (
        .clk(clk), .rst(rst), .tick_i(tick_i), .active_i(active),
        .n_rows_i(n_rows), .n_cols_i(n_cols), .deb_i(deb), .rate_i(rate),
        .rows_i(row_s), .col_drive_o(col_drive),
        .det_o(det), .det_col_o(det_col), .det_row_o(det_row)
    );

    assign col_o = ctrl.bypass ? col_reg : col_drive;
    assign irq_o = flag && ctrl.irq_en;

    // R10: idle scanner drives no column
    a_r10_idle_cols: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.scan_en && !ctrl.bypass) |-> (col_o == '1));
endmodule

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;
    logic       clk = 1'b0;
    logic       rst;
    logic       tick_i;
    logic [5:0] row_i;
    logic [4:0] col_o;
    logic       reg_wr;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq_o;

    logic       key_on;
    logic [2:0] key_c, key_r;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    keypad_scanner i_keypad_scanner (
        .clk(clk), .rst(rst), .tick_i(tick_i), .row_i(row_i), .col_o(col_o),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // switch matrix model: a pressed key pulls its row low while its column is driven
    always_comb begin
        row_i = '1;
        if (key_on && !col_o[key_c]) row_i[key_r] = 1'b0;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            repeat (4) @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        key_on = 1'b0; key_c = '0; key_r = '0;
        tick_i = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic press(input logic [2:0] c, input logic [2:0] r);
        key_c = c; key_r = r; key_on = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        chk("R1 col_o", int'(col_o), 'h1F);
        chk("R1 irq", int'(irq_o), 0);
        rd(3'd0, d); chk("R1 ctrl", int'(d), 'h00);
        rd(3'd4, d); chk("R1 col reg", int'(d), 'h1F);
        rd(3'd5, d); chk("R1 row reg", int'(d), 'h3F);
    endtask

    task automatic t_scan_rate();
        logic [7:0] d;
        do_reset();
        wr(3'd1, 8'h36);
        rd(3'd1, d); chk("R2 size readback", int'(d), 'h36);
        wr(3'd3, 8'd3); wr(3'd2, 8'd2); wr(3'd0, 8'h01);
        @(negedge clk);
        chk("R3 first column", int'(col_o), 'h1E);
        ticks(2); chk("R3 held", int'(col_o), 'h1E);
        ticks(1); chk("R3 step", int'(col_o), 'h1D);
        ticks(3); chk("R3 col2", int'(col_o), 'h1B);
        ticks(3); chk("R3/R6 wrap after 3 cols", int'(col_o), 'h1E);
    endtask

    task automatic t_press_irq();
        logic [7:0] d;
        do_reset();
        wr(3'd1, 8'h56); wr(3'd3, 8'd50); wr(3'd2, 8'd3); wr(3'd0, 8'h01);
        press(3'd0, 3'd4);
        ticks(1);
        ticks(2);
        rd(3'd0, d); chk("R4 not yet qualified", int'(d[3]), 0);
        ticks(1);
        rd(3'd0, d); chk("R4 flag", int'(d[3]), 1);
        chk("R8 irq gated", int'(irq_o), 0);
        rd(3'd4, d); chk("R4 col reg", int'(d), 'h1E);
        rd(3'd5, d); chk("R4 row reg", int'(d), 'h2F);
        wr(3'd0, 8'h03);
        @(negedge clk); chk("R8 irq on", int'(irq_o), 1);
        wr(3'd0, 8'h0B);
        @(negedge clk); chk("R8 irq cleared", int'(irq_o), 0);
        rd(3'd0, d); chk("R8 flag cleared", int'(d[3]), 0);
        ticks(5);
        rd(3'd0, d); chk("R7 no re-report while held", int'(d[3]), 0);
        chk("R7 column held", int'(col_o), 'h1E);
    endtask

    task automatic t_release();
        logic [7:0] d;
        do_reset();
        wr(3'd1, 8'h56); wr(3'd3, 8'd1); wr(3'd2, 8'd2); wr(3'd0, 8'h01);
        press(3'd2, 3'd1);
        ticks(10);
        rd(3'd0, d); chk("R4 flag col2", int'(d[3]), 1);
        rd(3'd4, d); chk("R4 col reg col2", int'(d), 'h1B);
        rd(3'd5, d); chk("R4 row reg row1", int'(d), 'h3D);
        key_on = 1'b0;
        ticks(1);
        press(3'd2, 3'd1);
        ticks(1);
        key_on = 1'b0;
        ticks(2); chk("R7 release restarted", int'(col_o), 'h1B);
        ticks(1); chk("R7 resume at col0", int'(col_o), 'h1E);
    endtask

    task automatic t_bounce();
        logic [7:0] d;
        do_reset();
        wr(3'd1, 8'h56); wr(3'd3, 8'd50); wr(3'd2, 8'd4); wr(3'd0, 8'h01);
        press(3'd0, 3'd3);
        ticks(2);
        key_on = 1'b0;
        ticks(7);
        rd(3'd0, d); chk("R5 bounce rejected", int'(d[3]), 0);
        press(3'd0, 3'd3);
        ticks(5);
        rd(3'd0, d); chk("R5 steady press accepted", int'(d[3]), 1);
    endtask

    task automatic t_rows_mask();
        logic [7:0] d;
        do_reset();
        wr(3'd1, 8'h53); wr(3'd3, 8'd1); wr(3'd2, 8'd1); wr(3'd0, 8'h01);
        press(3'd1, 3'd4);
        ticks(15);
        rd(3'd0, d); chk("R6 masked row ignored", int'(d[3]), 0);
        wr(3'd1, 8'h50);
        ticks(15);
        rd(3'd0, d); chk("R2 zero rows clamps to max", int'(d[3]), 1);
        rd(3'd5, d); chk("R2 row reg", int'(d), 'h2F);
        rd(3'd4, d); chk("R2 col reg", int'(d), 'h1D);
    endtask

    task automatic t_bypass();
        logic [7:0] d;
        do_reset();
        wr(3'd4, 8'h0A);
        rd(3'd4, d); chk("R9 write ignored outside bypass", int'(d), 'h1F);
        wr(3'd0, 8'h05);
        @(negedge clk); chk("R9 bypass col_o", int'(col_o), 'h1F);
        wr(3'd4, 8'h15);
        @(negedge clk); chk("R9 sw drives cols", int'(col_o), 'h15);
        press(3'd1, 3'd2);
        repeat (3) @(negedge clk);
        rd(3'd5, d); chk("R9 live rows", int'(d), 'h3B);
        ticks(5);
        rd(3'd0, d); chk("R9 no scan detect", int'(d[3]), 0);
        chk("R9 cols unchanged", int'(col_o), 'h15);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        do_reset();
        wr(3'd1, 8'h56); wr(3'd3, 8'd1); wr(3'd2, 8'd1);
        press(3'd0, 3'd0);
        ticks(10);
        chk("R10 cols idle", int'(col_o), 'h1F);
        rd(3'd0, d); chk("R10 no detect", int'(d[3]), 0);
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        t_reset();
        t_scan_rate();
        t_press_irq();
        t_release();
        t_bounce();
        t_rows_mask();
        t_bypass();
        t_disabled();
        finish_up();
    end
endmodule